// File: doc/BRIEF.md
# Stepper Winding Sequence Generator

This block drives the control inputs of two H-bridge current choppers that feed the two windings of a bipolar stepper motor. For each winding it produces a direction bit and a two-bit current-level code. A position counter walks around an eight-position electrical cycle. Each step pulse moves it forward or backward, by one position in half-step mode and by two in full-step mode.

The level code follows the position. In half-step mode a winding that conducts alone gets the full level. When both windings conduct, each gets two-thirds, so the torque stays about the same from step to step. A winding whose current passes through zero is switched fully off so that its current decays fast. After a programmable number of idle clocks the block drops to a one-third holding level. The step that ends a hold, or the first step after reset, starts a short boost at full level.

Top module: `step_seq_gen`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first step, the position is 0, every winding's code is off ({i1,i0} = 2'b11) and every direction bit is 0.
- R2: In half-step mode (`half_i`=1), each clock with `step_i`=1 moves the position by +1 when `dir_i`=1 and by -1 when `dir_i`=0, modulo 8. The new position is visible after that clock edge. Without a step the position holds.
- R3: In full-step mode (`half_i`=0), a step from an odd position moves by two (+2 forward, -2 reverse, modulo 8). A step from an even position moves to the adjacent odd position in the chosen direction, so the position is always odd after a full step.
- R4: Winding A (index 0) has direction bit 1 at positions 7, 0 and 1, and 0 elsewhere. Winding B (index 1) has direction bit 1 at positions 1, 2 and 3, and 0 elsewhere.
- R5: Winding A is off ({i1,i0}=2'b11) at positions 2 and 6. Winding B is off at positions 0 and 4.
- R6: In half-step mode with no hold and no boost, every winding at an odd position uses two-thirds ({i1,i0}=2'b01). The single conducting winding at an even position uses full ({i1,i0}=2'b00).
- R7: In full-step mode with no hold, both windings conduct at full level ({i1,i0}=2'b00).
- R8: After HOLD_CYCLES consecutive clocks without a step, the block is in hold. Every conducting winding then uses one-third ({i1,i0}=2'b10), and windings at their zero positions stay off.
- R9: A step clears hold. A step that arrives in the very clock at which hold would otherwise begin takes precedence, and hold does not begin.
- R10: The first step after reset, or a step taken during hold, starts a boost. That step and the next BOOST_STEPS-1 steps drive every conducting winding at full level. Hold beginning cancels any remaining boost.
- R11: Idle clocks before the first step after reset do not start hold; the windings stay off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One step per clock it is high |
| dir_i | input | 1 | 1 = forward, 0 = reverse |
| half_i | input | 1 | 1 = half-step mode, 0 = full-step mode |
| ph_o | output | 2 | Direction bit per winding (bit 0 = A, bit 1 = B) |
| i0_o | output | 2 | Low bit of each winding's level code |
| i1_o | output | 2 | High bit of each winding's level code |

## Verification
A step and the end of the idle window can fall in the same clock. In that clock the step must win, hold must stay clear, and no new boost may start. The bench provokes this by idling exactly HOLD_CYCLES-1 clocks and then stepping. It then checks that both windings show the nominal half-step levels and not the boosted full level. It then idles HOLD_CYCLES-1 clocks again and confirms that hold has not begun, which shows the idle count restarted. Hold beginning and boost are also made to meet, and a pending boost must vanish once hold is reached.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  localparam int unsigned NUM_WIND = 2;
  localparam int unsigned POS_W    = 3;

  typedef logic [POS_W-1:0] pos_t;

  // drive strength, ordered weakest to strongest
  typedef enum logic [1:0] {
    LVL_OFF   = 2'd0,
    LVL_THIRD = 2'd1,
    LVL_TWO3  = 2'd2,
    LVL_FULL  = 2'd3
  } lvl_e;

  // {i1,i0} pin code is the inverse of the strength
  function automatic logic [1:0] lvl_code(lvl_e l);
    return ~l;
  endfunction
endpackage

// File: rtl/step_idx_ctr.sv
module step_idx_ctr
  import step_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic dir_i,
  input  logic half_i,
  output pos_t pos_o
);
  pos_t pos_q, delta, pos_d;

  always_comb begin
    // full step from even snaps to neighbouring odd
    if (half_i || !pos_q[0]) delta = pos_t'(1);
    else                     delta = pos_t'(2);
    pos_d = dir_i ? pos_q + delta : pos_q - delta;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (step_i) pos_q <= pos_d;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/step_idle_mon.sv
module step_idle_mon #(
  parameter int unsigned HOLD_CYCLES = 1000,
  parameter int unsigned BOOST_STEPS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic en_o,
  output logic hold_o,
  output logic boost_o
);
  localparam int unsigned IW = $clog2(HOLD_CYCLES + 1);
  localparam int unsigned BW = $clog2(BOOST_STEPS + 2);

  logic          en_q, hold_q;
  logic [IW-1:0] idle_q;
  logic [BW-1:0] boost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      hold_q  <= 1'b0;
      idle_q  <= '0;
      boost_q <= '0;
    end else if (step_i) begin
      en_q   <= 1'b1;
      hold_q <= 1'b0;
      idle_q <= '0;
      if (!en_q || hold_q)    boost_q <= BW'(BOOST_STEPS);
      else if (boost_q != '0) boost_q <= boost_q - BW'(1);
    end else if (en_q && !hold_q) begin
      if (idle_q == IW'(HOLD_CYCLES - 1)) begin
        hold_q  <= 1'b1;
        boost_q <= '0;
      end else begin
        idle_q <= idle_q + IW'(1);
      end
    end
  end

  assign en_o    = en_q;
  assign hold_o  = hold_q;
  assign boost_o = (boost_q != '0);
endmodule

// File: rtl/step_lvl_dec.sv
module step_lvl_dec
  import step_seq_pkg::*;
#(
  parameter int unsigned W_IDX = 0
) (
  input  pos_t pos_i,
  input  logic half_i,
  input  logic en_i,
  input  logic hold_i,
  input  logic boost_i,
  output logic ph_o,
  output logic i0_o,
  output logic i1_o
);
  // each winding lags the previous by a quarter cycle
  localparam pos_t OFFS = pos_t'(2 * W_IDX);

  pos_t       rel;
  logic       zero, pos_sgn;
  lvl_e       lvl;
  logic [1:0] code;

  always_comb begin
    rel     = pos_i - OFFS;
    zero    = (rel == pos_t'(2)) || (rel == pos_t'(6));
    pos_sgn = (rel == pos_t'(7)) || (rel == pos_t'(0)) || (rel == pos_t'(1));
    if (!en_i || zero)            lvl = LVL_OFF;
    else if (hold_i)              lvl = LVL_THIRD;
    else if (boost_i)             lvl = LVL_FULL;
    else if (half_i && pos_i[0])  lvl = LVL_TWO3;
    else                          lvl = LVL_FULL;
    code = lvl_code(lvl);
  end

  assign ph_o = en_i & pos_sgn;
  assign i1_o = code[1];
  assign i0_o = code[0];
endmodule

// File: rtl/step_seq_gen.sv
module step_seq_gen
  import step_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 1000,
  parameter int unsigned BOOST_STEPS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic                dir_i,
  input  logic                half_i,
  output logic [NUM_WIND-1:0] ph_o,
  output logic [NUM_WIND-1:0] i0_o,
  output logic [NUM_WIND-1:0] i1_o
);
  pos_t pos;
  logic en, hold, boost;

  step_idx_ctr u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .dir_i  (dir_i),
    .half_i (half_i),
    .pos_o  (pos)
  );

  step_idle_mon #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .BOOST_STEPS (BOOST_STEPS)
  ) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_i),
    .en_o    (en),
    .hold_o  (hold),
    .boost_o (boost)
  );

  for (genvar w = 0; w < NUM_WIND; w++) begin : g_wind
    step_lvl_dec #(.W_IDX(w)) u_dec (
      .pos_i   (pos),
      .half_i  (half_i),
      .en_i    (en),
      .hold_i  (hold),
      .boost_i (boost),
      .ph_o    (ph_o[w]),
      .i0_o    (i0_o[w]),
      .i1_o    (i1_o[w])
    );
  end
endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk
  import step_seq_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                step_i,
  input logic                dir_i,
  input logic                half_i,
  input pos_t                pos,
  input logic                en,
  input logic                hold,
  input logic [NUM_WIND-1:0] ph_o,
  input logic [NUM_WIND-1:0] i0_o,
  input logic [NUM_WIND-1:0] i1_o
);
  a_r1_off_before_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (i0_o == '1) && (i1_o == '1) && (ph_o == '0));

  a_r2_half_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && half_i |=> pos == ($past(dir_i) ? pos_t'($past(pos) + pos_t'(1))
                                              : pos_t'($past(pos) - pos_t'(1))));

  a_r2_hold_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos));

  a_r3_full_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !half_i |=> pos[0]);

  a_r5_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos[1:0] == 2'd2) |-> i0_o[0] && i1_o[0]);

  a_r5_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos[1:0] == 2'd0) |-> i0_o[1] && i1_o[1]);

  a_r9_step_clears_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> !hold);

  a_r11_no_hold_unstarted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !hold);
endmodule

bind step_seq_gen step_seq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .step_i (step_i),
  .dir_i  (dir_i),
  .half_i (half_i),
  .pos    (pos),
  .en     (en),
  .hold   (hold),
  .ph_o   (ph_o),
  .i0_o   (i0_o),
  .i1_o   (i1_o)
);

// File: tb/sim_step_seq_gen.sv
module sim_step_seq_gen;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int HOLD  = 6;
  localparam int BOOST = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic step_i = 1'b0, dir_i = 1'b1, half_i = 1'b1;
  logic [1:0] ph_o, i0_o, i1_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // model state
  int  m_pos = 0, m_idle = 0, m_boost = 0;
  bit  m_en = 0, m_hold = 0;

  always #2.5 clk = ~clk;

  step_seq_gen #(.HOLD_CYCLES(HOLD), .BOOST_STEPS(BOOST)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .dir_i(dir_i), .half_i(half_i),
    .ph_o(ph_o), .i0_o(i0_o), .i1_o(i1_o)
  );

  // {ph, i1, i0} expected for winding w
  function automatic logic [2:0] expect_w(int w);
    int rel, lvl;
    bit zero, sgn;
    rel  = (m_pos - 2 * w) & 7;
    zero = (rel == 2) || (rel == 6);
    sgn  = (rel == 7) || (rel == 0) || (rel == 1);
    if (!m_en || zero)             lvl = 0;
    else if (m_hold)               lvl = 1;
    else if (m_boost > 0)          lvl = 3;
    else if (half_i && m_pos % 2)  lvl = 2;
    else                           lvl = 3;
    return {m_en & sgn, 2'(3 - lvl)};
  endfunction

  task automatic check(string tag);
    logic [2:0] got, exp;
    bit bad = 0;
    n_tests++;
    for (int w = 0; w < 2; w++) begin
      got = {ph_o[w], i1_o[w], i0_o[w]};
      exp = expect_w(w);
      if (got !== exp) begin
        bad = 1;
        $display("FAIL %s winding %0d pos %0d: got %b expected %b", tag, w, m_pos, got, exp);
      end
    end
    if (bad) n_fail++;
  endtask

  task automatic cyc(bit s, bit d, bit h, string tag);
    int delta;
    step_i = s; dir_i = d; half_i = h;
    @(negedge clk);
    if (s) begin
      delta  = (h || (m_pos % 2 == 0)) ? 1 : 2;
      m_pos  = (m_pos + (d ? delta : 8 - delta)) & 7;
      m_boost = (!m_en || m_hold) ? BOOST : (m_boost > 0 ? m_boost - 1 : 0);
      m_en   = 1; m_hold = 0; m_idle = 0;
    end else if (m_en && !m_hold) begin
      if (m_idle == HOLD - 1) begin m_hold = 1; m_boost = 0; end
      else m_idle++;
    end
    step_i = 1'b0;
    check(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_pos = 0; m_idle = 0; m_boost = 0; m_en = 0; m_hold = 0;
    @(negedge clk);
    check("R1 in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < HOLD + 3; i++) cyc(0, 1, 1, "R11 idle before start");
    // first step boosts
    for (int i = 0; i < 18; i++) cyc(1, 1, 1, "R2 R4 R5 R6 R10 half fwd");
    for (int i = 0; i < 18; i++) cyc(1, 0, 1, "R2 R4 R5 R6 half rev");
    for (int i = 0; i < HOLD + 2; i++) cyc(0, 0, 1, "R8 hold entry");
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, "R9 R10 leave hold");
    // full step sweeps
    for (int i = 0; i < 9; i++) cyc(1, 1, 0, "R3 R7 full fwd");
    for (int i = 0; i < 9; i++) cyc(1, 0, 0, "R3 R7 full rev");
    // snap from every even position both ways
    for (int p = 0; p < 8; p++) begin
      cyc(1, 1, 1, "R2 position");
      if (m_pos % 2 == 0) begin
        cyc(1, p % 2 == 0, 0, "R3 even snap");
        cyc(1, 1, 1, "R2 back to half");
      end
    end
    // step in the clock hold would begin
    cyc(1, 1, 1, "R2 settle");
    for (int i = 0; i < HOLD - 1; i++) cyc(0, 1, 1, "R9 below limit");
    cyc(1, 1, 1, "R9 step beats hold");
    for (int i = 0; i < HOLD - 1; i++) cyc(0, 1, 1, "R9 count restarted");
    cyc(0, 1, 1, "R8 hold reached");
    // hold cancels pending boost
    cyc(1, 1, 1, "R10 boost start");
    for (int i = 0; i < HOLD + 1; i++) cyc(0, 1, 0, "R8 R10 hold in full");
    cyc(1, 0, 0, "R10 boost after hold");
    // mode change without step
    cyc(0, 0, 1, "R6 mode switch");
    do_reset();
    cyc(0, 1, 1, "R11 idle after reset");
    cyc(1, 0, 0, "R3 R10 first step full rev");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule